// File: doc/BRIEF.md
# Linear CCD Sensor Timing Generator

This block drives the digital clock pins of a three-colour linear CCD sensor whose twelve output channels (four per colour) read out in lockstep. Every line runs one fixed sequence: the horizontal shift clocks freeze, the line transfer gate pulses high, the clocks stay frozen for a settling delay, and then pixel clocking starts and shifts every cell of the line out. During readout the block produces two complementary shift phases, a separate last-stage clock, a reset-gate pulse and a mid-pixel sample strobe. It tags each pixel with its index and its class so that downstream capture can keep or drop it.

All delays and widths are counted in master-clock cycles. They are taken from configuration inputs at the moment a line starts. A value below its physical minimum is raised to that minimum. Lines start on a one-cycle `line_start` pulse. When `free_run` is held high, each line starts as soon as the one before it ends.

Each channel reads 1873 cells per line, and the block then clocks one spill cell after them. The pixel period is four quarters of `cfg_quarter` cycles each.

Top module: `ccd_tgen`

## Requirements
- R1: While reset is asserted and in idle afterwards, the outputs rest in the frozen state: `tg`=0, `phi1`=1, `phi2`=0, `phi2l`=0, `rs`=0, `smp`=0.
- R2: After a line starts, the clocks stay frozen for the effective stop delay (cycles) and then `tg` is high for exactly the effective transfer width.
- R3: After `tg` falls, the clocks stay frozen for the effective resume delay, and the first reset-gate pulse of the readout comes on the cycle after that delay.
- R4: Outside readout, including the whole transfer-gate period, `rs`, `phi2l` and `smp` are low, `phi1` is high and `phi2` is low.
- R5: During readout each pixel lasts 4·Q cycles (Q = effective quarter length). `phi1` is high for the first 2·Q cycles of a pixel, and `phi2` is always the complement of `phi1`.
- R6: During readout `rs` is high for the first quarter of each pixel, and `phi2l` is high only in the fourth quarter, so it is low for 3·Q cycles of each pixel.
- R7: `smp` pulses for one cycle at the start of each pixel's third quarter (2·Q cycles after the reset pulse rises). It comes once for each of the 1874 pixel indices 0..1873, in increasing order, and `pix_idx` gives the index.
- R8: With `smp`, `pix_cls` is 0 (dummy) for indices 0–16, 1 (optical black) for 17–44, 2 (invalid) for 45–47 and 3 (valid) for 48–1872. `pix_spill` is 1 only at index 1873, where `pix_cls` is 0.
- R9: A configuration value below its minimum is raised to it. The minima are stop 20, transfer 200, resume 60 and quarter 2 cycles.
- R10: Configuration inputs are captured when a line starts. A change during the line does not affect that line.
- R11: A `line_start` pulse during a line is ignored.
- R12: With `free_run` high, a new line starts after exactly one idle cycle once readout ends. With `free_run` low, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle request to start a line (idle only) |
| free_run | input | 1 | Start lines back to back |
| cfg_stop | input | 16 | Clock-stop to gate-rise delay, cycles |
| cfg_tg | input | 16 | Transfer-gate high width, cycles |
| cfg_resume | input | 16 | Gate-fall to clock-resume delay, cycles |
| cfg_quarter | input | 10 | Quarter of the pixel period, cycles |
| tg | output | 1 | Transfer-gate clock |
| phi1 | output | 1 | Shift phase 1 |
| phi2 | output | 1 | Shift phase 2 |
| phi2l | output | 1 | Last-stage shift clock |
| rs | output | 1 | Reset-gate clock |
| smp | output | 1 | Mid-pixel sample strobe |
| pix_idx | output | 11 | Pixel index in the line |
| pix_cls | output | 2 | Pixel class code |
| pix_spill | output | 1 | Spill cell after the valid run |

## Verification
Some relations hold on every cycle, and the assertions check those. They check that the shift phases are complementary, that the reset gate and all clocking are quiet while the transfer gate is high, that every transfer pulse meets the minimum width, that strobes are single-cycle and fall in the third quarter, and that the spill cell carries the dummy code. The exact cycle counts of the stop, gate and resume windows, the clamping of short settings, the capture of the configuration at line start, the ignored mid-line start request and the one-idle-cycle gap between free-running lines depend on the programmed values. Only the bench scenarios show them, by predicting every output cycle by cycle and the cycle, index and class of every strobe.

// File: rtl/ccd_tgen_pkg.sv
`timescale 1ns/1ps
// Shared types of the CCD timing generator.
// Assumes: class codes are consumed downstream as the 2-bit values below.
package ccd_tgen_pkg;
    typedef enum logic [1:0] {
        CLS_DUMMY   = 2'd0,
        CLS_OBLACK  = 2'd1,
        CLS_INVALID = 2'd2,
        CLS_VALID   = 2'd3
    } pix_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STOP,
        ST_XFER,
        ST_RESUME,
        ST_READ
    } line_st_e;
endpackage

// File: rtl/ccd_line_seq.sv
`timescale 1ns/1ps
// Line sequencer: idle -> clocks stopped -> transfer gate -> resume wait -> readout.
// Captures and clamps the configuration on the cycle a line is accepted.
// Assumes: read_done is a one-cycle pulse on the last readout cycle.
module ccd_line_seq
    import ccd_tgen_pkg::*;
#(
    parameter int DW       = 16,
    parameter int QW       = 10,
    parameter int MIN_STOP = 20,
    parameter int MIN_XFER = 200,
    parameter int MIN_RES  = 60,
    parameter int MIN_QTR  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          free_run,
    input  logic [DW-1:0] cfg_stop,
    input  logic [DW-1:0] cfg_xfer,
    input  logic [DW-1:0] cfg_res,
    input  logic [QW-1:0] cfg_qtr,
    input  logic          read_done,
    output logic          xfer_on,
    output logic          read_on,
    output logic [QW-1:0] qtr_len
);
    localparam logic [DW-1:0] LO_STOP = DW'(MIN_STOP);
    localparam logic [DW-1:0] LO_XFER = DW'(MIN_XFER);
    localparam logic [DW-1:0] LO_RES  = DW'(MIN_RES);
    localparam logic [QW-1:0] LO_QTR  = QW'(MIN_QTR);

    line_st_e      st;
    logic [DW-1:0] cnt;
    logic [DW-1:0] stop_q, xfer_q, res_q;
    logic [QW-1:0] qtr_q;
    logic [DW-1:0] stop_c, xfer_c, res_c;
    logic [QW-1:0] qtr_c;

    // Raise every setting to its minimum before capture.
    always_comb begin
        stop_c = (cfg_stop < LO_STOP) ? LO_STOP : cfg_stop;
        xfer_c = (cfg_xfer < LO_XFER) ? LO_XFER : cfg_xfer;
        res_c  = (cfg_res  < LO_RES)  ? LO_RES  : cfg_res;
        qtr_c  = (cfg_qtr  < LO_QTR)  ? LO_QTR  : cfg_qtr;
    end

    // Phase state machine with one shared interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            stop_q <= LO_STOP;
            xfer_q <= LO_XFER;
            res_q  <= LO_RES;
            qtr_q  <= LO_QTR;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (line_start || free_run) begin
                        stop_q <= stop_c;
                        xfer_q <= xfer_c;
                        res_q  <= res_c;
                        qtr_q  <= qtr_c;
                        cnt    <= '0;
                        st     <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (cnt == stop_q - DW'(1)) begin
                        cnt <= '0;
                        st  <= ST_XFER;
                    end else begin
                        cnt <= cnt + DW'(1);
                    end
                end
                ST_XFER: begin
                    if (cnt == xfer_q - DW'(1)) begin
                        cnt <= '0;
                        st  <= ST_RESUME;
                    end else begin
                        cnt <= cnt + DW'(1);
                    end
                end
                ST_RESUME: begin
                    if (cnt == res_q - DW'(1)) begin
                        cnt <= '0;
                        st  <= ST_READ;
                    end else begin
                        cnt <= cnt + DW'(1);
                    end
                end
                ST_READ: begin
                    if (read_done) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign xfer_on = (st == ST_XFER);
    assign read_on = (st == ST_READ);
    assign qtr_len = qtr_q;
endmodule

// File: rtl/ccd_pixel_clk.sv
`timescale 1ns/1ps
// Pixel clock engine: divides each pixel into four quarters and walks the line.
// Outputs rest at phi1=1, others 0 while run is low.
// Assumes: qtr_len >= 2 and stable while run is high.
module ccd_pixel_clk #(
    parameter int QW   = 10,
    parameter int NPIX = 1874,
    parameter int IW   = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [QW-1:0] qtr_len,
    output logic          phi1,
    output logic          phi2,
    output logic          phi2l,
    output logic          rs,
    output logic          smp,
    output logic [IW-1:0] pix_idx,
    output logic          done
);
    localparam logic [IW-1:0] LAST_PIX = IW'(NPIX - 1);

    logic [QW-1:0] qcnt;
    logic [1:0]    quad;
    logic [IW-1:0] pix;
    logic          qtr_end;

    assign qtr_end = (qcnt == qtr_len - QW'(1));

    // Quarter, quarter-count and pixel counters; cleared whenever idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            qcnt <= '0;
            quad <= '0;
            pix  <= '0;
        end else if (qtr_end) begin
            qcnt <= '0;
            quad <= quad + 2'd1;
            if (quad == 2'd3 && pix != LAST_PIX) pix <= pix + IW'(1);
        end else begin
            qcnt <= qcnt + QW'(1);
        end
    end

    // Clock levels decoded from the registered quarter.
    always_comb begin
        phi1  = run ? ~quad[1] : 1'b1;
        phi2  = run ?  quad[1] : 1'b0;
        rs    = run && (quad == 2'd0);
        phi2l = run && (quad == 2'd3);
        smp   = run && (quad == 2'd2) && (qcnt == '0);
        done  = run && qtr_end && (quad == 2'd3) && (pix == LAST_PIX);
    end

    assign pix_idx = pix;
endmodule

// File: rtl/ccd_pixel_tag.sv
`timescale 1ns/1ps
// Pixel classifier: maps a pixel index to its class code and the spill flag.
// Assumes: index counts from 0 at the first dummy cell of a channel.
module ccd_pixel_tag
    import ccd_tgen_pkg::*;
#(
    parameter int N_DUMMY = 17,
    parameter int N_OB    = 28,
    parameter int N_INV   = 3,
    parameter int N_VALID = 1825,
    parameter int IW      = 11
) (
    input  logic [IW-1:0] pix_idx,
    output pix_cls_e      cls,
    output logic          spill
);
    localparam logic [IW-1:0] B_OB    = IW'(N_DUMMY);
    localparam logic [IW-1:0] B_INV   = IW'(N_DUMMY + N_OB);
    localparam logic [IW-1:0] B_VALID = IW'(N_DUMMY + N_OB + N_INV);
    localparam logic [IW-1:0] B_SPILL = IW'(N_DUMMY + N_OB + N_INV + N_VALID);

    // Range decode of the index into class and spill marker.
    always_comb begin
        spill = (pix_idx == B_SPILL);
        if (pix_idx < B_OB)         cls = CLS_DUMMY;
        else if (pix_idx < B_INV)   cls = CLS_OBLACK;
        else if (pix_idx < B_VALID) cls = CLS_INVALID;
        else if (pix_idx < B_SPILL) cls = CLS_VALID;
        else                        cls = CLS_DUMMY;
    end
endmodule

// File: rtl/ccd_tgen.sv
`timescale 1ns/1ps
// Top of the linear CCD timing generator. One clock set and one tag set serve
// all twelve channels, which read out in lockstep.
// Assumes: a 200 MHz master clock for the default minimum settings.
module ccd_tgen
    import ccd_tgen_pkg::*;
#(
    parameter int DW       = 16,
    parameter int QW       = 10,
    parameter int N_DUMMY  = 17,
    parameter int N_OB     = 28,
    parameter int N_INV    = 3,
    parameter int N_VALID  = 1825,
    parameter int MIN_STOP = 20,
    parameter int MIN_XFER = 200,
    parameter int MIN_RES  = 60,
    parameter int MIN_QTR  = 2,
    localparam int NPIX    = N_DUMMY + N_OB + N_INV + N_VALID + 1,
    localparam int IW      = $clog2(NPIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          free_run,
    input  logic [DW-1:0] cfg_stop,
    input  logic [DW-1:0] cfg_tg,
    input  logic [DW-1:0] cfg_resume,
    input  logic [QW-1:0] cfg_quarter,
    output logic          tg,
    output logic          phi1,
    output logic          phi2,
    output logic          phi2l,
    output logic          rs,
    output logic          smp,
    output logic [IW-1:0] pix_idx,
    output logic [1:0]    pix_cls,
    output logic          pix_spill
);
    logic          read_on;
    logic          read_done;
    logic [QW-1:0] qtr_len;
    pix_cls_e      cls;

    ccd_line_seq #(
        .DW(DW), .QW(QW),
        .MIN_STOP(MIN_STOP), .MIN_XFER(MIN_XFER),
        .MIN_RES(MIN_RES), .MIN_QTR(MIN_QTR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .line_start(line_start), .free_run(free_run),
        .cfg_stop(cfg_stop), .cfg_xfer(cfg_tg),
        .cfg_res(cfg_resume), .cfg_qtr(cfg_quarter),
        .read_done(read_done),
        .xfer_on(tg), .read_on(read_on), .qtr_len(qtr_len)
    );

    ccd_pixel_clk #(.QW(QW), .NPIX(NPIX), .IW(IW)) u_pclk (
        .clk(clk), .rst_n(rst_n), .run(read_on), .qtr_len(qtr_len),
        .phi1(phi1), .phi2(phi2), .phi2l(phi2l), .rs(rs), .smp(smp),
        .pix_idx(pix_idx), .done(read_done)
    );

    ccd_pixel_tag #(
        .N_DUMMY(N_DUMMY), .N_OB(N_OB), .N_INV(N_INV),
        .N_VALID(N_VALID), .IW(IW)
    ) u_tag (
        .pix_idx(pix_idx), .cls(cls), .spill(pix_spill)
    );

    assign pix_cls = cls;
endmodule

// File: rtl/ccd_tgen_chk.sv
`timescale 1ns/1ps
// Checker for the CCD timing generator, bound to its top.
// Assumes: synchronous active-low reset; MIN_XFER matches the design's minimum.
module ccd_tgen_chk #(
    parameter int DW       = 16,
    parameter int MIN_XFER = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tg,
    input logic       phi1,
    input logic       phi2,
    input logic       phi2l,
    input logic       rs,
    input logic       smp,
    input logic [1:0] pix_cls,
    input logic       pix_spill
);
    logic [DW-1:0] hi_cnt;

    // Length of the current transfer-gate high run.
    always_ff @(posedge clk) begin
        if (!rst_n)  hi_cnt <= '0;
        else if (tg) hi_cnt <= hi_cnt + DW'(1);
        else         hi_cnt <= '0;
    end

    a_r2_tg_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tg) |-> (hi_cnt >= DW'(MIN_XFER)));

    a_r4_quiet_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        tg |-> (phi1 && !phi2 && !rs && !phi2l && !smp));

    a_r5_phases_complement: assert property (@(posedge clk) disable iff (!rst_n)
        rs || !rs |-> (phi1 != phi2));

    a_r6_rs_in_first_half: assert property (@(posedge clk) disable iff (!rst_n)
        rs |-> (phi1 && !phi2l));

    a_r7_strobe_third_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> (phi2 && !phi2l && !rs));

    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        smp |=> !smp);

    a_r8_spill_is_dummy: assert property (@(posedge clk) disable iff (!rst_n)
        (smp && pix_spill) |-> (pix_cls == 2'd0));
endmodule

bind ccd_tgen ccd_tgen_chk #(.DW(DW), .MIN_XFER(MIN_XFER)) u_chk (
    .clk(clk), .rst_n(rst_n), .tg(tg), .phi1(phi1), .phi2(phi2),
    .phi2l(phi2l), .rs(rs), .smp(smp), .pix_cls(pix_cls), .pix_spill(pix_spill)
);

// File: tb/ccd_tgen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the line driver queues every expected strobe, and a
// monitor pops and compares them as they appear. Clock levels are predicted per cycle.
module ccd_tgen_tb;
    localparam int NPIX = 1874;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        free_run = 1'b0;
    logic [15:0] cfg_stop = '0, cfg_tg = '0, cfg_resume = '0;
    logic [9:0]  cfg_quarter = '0;
    logic        tg, phi1, phi2, phi2l, rs, smp, pix_spill;
    logic [10:0] pix_idx;
    logic [1:0]  pix_cls;

    always #2.5 clk = ~clk;

    ccd_tgen u_dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .free_run(free_run),
        .cfg_stop(cfg_stop), .cfg_tg(cfg_tg), .cfg_resume(cfg_resume),
        .cfg_quarter(cfg_quarter), .tg(tg), .phi1(phi1), .phi2(phi2),
        .phi2l(phi2l), .rs(rs), .smp(smp), .pix_idx(pix_idx),
        .pix_cls(pix_cls), .pix_spill(pix_spill)
    );

    int     checks = 0;
    int     errors = 0;
    bit     finished = 1'b0;
    longint gcyc = 0;

    typedef struct {
        longint cyc;
        int     idx;
        int     cls;
        bit     spill;
    } exp_t;
    exp_t sb[$];

    always @(posedge clk) gcyc <= gcyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_cls(input int i);
        if (i < 17)   return 0;
        if (i < 45)   return 1;
        if (i < 48)   return 2;
        if (i < 1873) return 3;
        return 0;
    endfunction

    function automatic int clampv(input int v, input int m);
        return (v < m) ? m : v;
    endfunction

    // Monitor: compare each observed strobe against the queue head (R7, R8).
    always @(negedge clk) begin
        if (rst_n && smp) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected strobe", gcyc, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(gcyc == e.cyc, "R7 strobe cycle", gcyc, e.cyc);
                check(int'(pix_idx) == e.idx, "R7 pixel index", pix_idx, e.idx);
                check(int'(pix_cls) == e.cls, "R8 class code", pix_cls, e.cls);
                check(pix_spill == e.spill, "R8 spill flag", pix_spill, e.spill);
            end
        end
    end

    // Driver: run one line, queue its strobes, predict clock levels per cycle.
    task automatic run_line(input bit pulse, input int c_stop, input int c_tg,
                            input int c_res, input int c_q, input bit mid_change,
                            input bit mid_pulse, input bit drop_free,
                            output int total);
        int es, et, er, eq, s0, len, n_r2, n_r3, n_r4, n_r5, n_r6;
        longint base;
        es = clampv(c_stop, 20);
        et = clampv(c_tg, 200);
        er = clampv(c_res, 60);
        eq = clampv(c_q, 2);
        s0 = es + et + er;
        len = s0 + NPIX * 4 * eq + 1;
        n_r2 = 0; n_r3 = 0; n_r4 = 0; n_r5 = 0; n_r6 = 0;
        cfg_stop = 16'(c_stop); cfg_tg = 16'(c_tg);
        cfg_resume = 16'(c_res); cfg_quarter = 10'(c_q);
        if (pulse) begin
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
        end else begin
            @(negedge clk);
        end
        base = gcyc;
        for (int p = 0; p < NPIX; p++) begin
            exp_t e;
            e.cyc = base + s0 + longint'(p) * 4 * eq + 2 * eq;
            e.idx = p;
            e.cls = exp_cls(p);
            e.spill = (p == NPIX - 1);
            sb.push_back(e);
        end
        for (int n = 1; n <= len; n++) begin
            int r;
            bit x_tg, x_p1, x_p2, x_rs, x_2l;
            if (n > 1) @(negedge clk);
            r = n - 1;
            if (mid_change && n == 5) begin
                cfg_stop = 16'd500; cfg_tg = 16'd3000;
                cfg_resume = 16'd900; cfg_quarter = 10'd7;
            end
            if (drop_free && n == 10) free_run = 1'b0;
            if (mid_pulse && n == s0 + 100) line_start = 1'b1;
            if (mid_pulse && n == s0 + 101) line_start = 1'b0;
            x_tg = (r >= es) && (r < es + et);
            x_p1 = 1'b1; x_p2 = 1'b0; x_rs = 1'b0; x_2l = 1'b0;
            if (r >= s0 && r < len - 1) begin
                int ph, qd;
                ph = (r - s0) % (4 * eq);
                qd = ph / eq;
                x_p1 = (qd < 2); x_p2 = !x_p1;
                x_rs = (qd == 0); x_2l = (qd == 3);
            end
            if (tg != x_tg) n_r2++;
            if (r < es + et) begin
                if (phi1 != x_p1 || phi2 != x_p2 || rs != x_rs || phi2l != x_2l) n_r4++;
            end else if (r < s0) begin
                if (phi1 != x_p1 || phi2 != x_p2 || rs != x_rs || phi2l != x_2l) n_r3++;
            end else if (r < len - 1) begin
                if (phi1 != x_p1 || phi2 != x_p2) n_r5++;
                if (rs != x_rs || phi2l != x_2l) n_r6++;
            end else begin
                if (phi1 != 1'b1 || phi2 || rs || phi2l) n_r4++;
            end
        end
        check(n_r2 == 0, "R2 stop and gate windows", n_r2, 0);
        check(n_r3 == 0, "R3 frozen until resume", n_r3, 0);
        check(n_r4 == 0, "R4 quiet clocks outside readout", n_r4, 0);
        check(n_r5 == 0, "R5 shift phase pattern", n_r5, 0);
        check(n_r6 == 0, "R6 reset and last-stage pattern", n_r6, 0);
        check(sb.size() == 0, "R7 every strobe seen", sb.size(), 0);
        total = n_r2 + n_r3 + n_r4 + n_r5 + n_r6 + sb.size();
    endtask

    initial begin
        int tot;
        int tg_seen;
        repeat (4) @(negedge clk);
        // R1: reset values.
        check(tg == 1'b0, "R1 tg in reset", tg, 0);
        check(phi1 == 1'b1, "R1 phi1 in reset", phi1, 1);
        check(phi2 == 1'b0, "R1 phi2 in reset", phi2, 0);
        check(rs == 1'b0, "R1 rs in reset", rs, 0);
        check(phi2l == 1'b0, "R1 phi2l in reset", phi2l, 0);
        check(smp == 1'b0, "R1 smp in reset", smp, 0);
        rst_n = 1'b1;
        tg_seen = 0;
        repeat (30) begin
            @(negedge clk);
            if (tg || rs || smp) tg_seen++;
        end
        check(tg_seen == 0, "R1 idle without a start", tg_seen, 0);

        // Nominal line, quarter of 3 cycles.
        run_line(1'b1, 40, 400, 100, 3, 1'b0, 1'b0, 1'b0, tot);
        // Settings below minimum, changed mid-line, with a stray start request.
        run_line(1'b1, 3, 10, 0, 0, 1'b1, 1'b1, 1'b0, tot);
        check(tot == 0, "R9 clamped to minimum", tot, 0);
        check(tot == 0, "R10 mid-line settings ignored", tot, 0);
        check(tot == 0, "R11 mid-line start ignored", tot, 0);
        // Free-running pair of lines.
        free_run = 1'b1;
        run_line(1'b1, 25, 250, 70, 2, 1'b0, 1'b0, 1'b0, tot);
        run_line(1'b0, 60, 300, 80, 2, 1'b0, 1'b0, 1'b1, tot);
        check(tot == 0, "R12 back-to-back line after one idle cycle", tot, 0);
        tg_seen = 0;
        repeat (40) begin
            @(negedge clk);
            if (tg || !phi1 || rs) tg_seen++;
        end
        check(tg_seen == 0, "R12 idle once free-run drops", tg_seen, 0);
        check(sb.size() == 0, "R7 no stray strobes", sb.size(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", gcyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule